// File: doc/BRIEF.md
# Shared Upper-Half Pool Allocator for a Two-Block Compressed Line

This block keeps the data side of one physical cache line that holds up to two compressed blocks. Each stored block keeps only the low 16 bits of every 32-bit word in its normal half-width position. A word is narrow when its upper 16 bits are all copies of bit 15. For a word that is not narrow, its upper half goes into a small pool of extra half-word registers that both blocks share. A short per-word code records which pool entry holds that upper half. When every word of an incoming block is narrow, no pool entry is needed. When the block has a few wide words, it is still accepted as long as pool entries are free for it. Otherwise the fill is rejected, and the caller stores that block as a full-width block somewhere else.

Two allocation modes are selected by a parameter.

- **Fixed mode:** the pool has two entries. Each block owns one entry, so a block may contain at most one wide word.
- **Adaptive mode:** the pool has four entries, and the two blocks may take unequal shares. Each block is capped at three entries so that a 2-bit code can name them. Block 0 takes entries from index 0 upward. Block 1 takes entries from the top index downward. This keeps the free entries contiguous in the middle.

Reads take a block select and a word index, and return the rebuilt 32-bit word.

Top module: `ahw_line_alloc`

## Requirements
- R1: After reset, no block is resident. `fill_accept`, `fill_reject` and `rd_hit` are 0, and a read returns `rd_hit`=0 with `rd_data`=0.
- R2: A word whose bits 31..16 all equal bit 15 is narrow. It uses no pool entry, and a read returns its low half sign-extended to 32 bits.
- R3: A wide word in an accepted block reads back as its full original 32-bit value. The word with index w is `fill_data[32*w+31:32*w]`.
- R4: In adaptive mode (`ADAPTIVE`=1), a fill whose block has more than 3 wide words is rejected.
- R5: In adaptive mode, the two blocks may hold unequal numbers of wide words, with a combined total of at most 4. A fill is rejected when its wide-word count exceeds 4 minus the entries held by the other block.
- R6: In fixed mode (`ADAPTIVE`=0), a block with more than 1 wide word is rejected, and each block has its own single pool entry.
- R7: A rejected fill leaves both resident blocks and their read data unchanged.
- R8: An eviction makes its block non-resident, so reads return `rd_hit`=0 and `rd_data`=0. The evicted block's pool entries become free for later fills.
- R9: A fill that overwrites a resident block first releases that block's own pool entries, so those entries count as free for the new contents.
- R10: Exactly one of `fill_accept` or `fill_reject` pulses in the cycle after each fill request, and neither pulses in other cycles. Read results appear one cycle after `rd_valid`. A read returns the line contents as they were before any fill or eviction in the same cycle.
- R11: An eviction of the other block in the same cycle as a fill frees that block's entries for the fill. If an accepted fill and an eviction target the same block, the fill wins. If that fill is rejected, the eviction still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Request to store a block |
| fill_blk | input | 1 | Target block position (0 or 1) |
| fill_data | input | WORDS*32 | Block contents, word w at bits 32*w+31..32*w |
| evict_valid | input | 1 | Remove a resident block |
| evict_blk | input | 1 | Block position to remove |
| rd_valid | input | 1 | Read request |
| rd_blk | input | 1 | Block position to read |
| rd_word | input | $clog2(WORDS) | Word index to read |
| fill_accept | output | 1 | Fill was stored (one cycle after the request) |
| fill_reject | output | 1 | Fill did not fit (one cycle after the request) |
| rd_hit | output | 1 | Block was resident at the read |
| rd_data | output | 32 | Rebuilt 32-bit word |

## Verification
Both fill results and read data come from registers. Each is due on the first rising edge after the cycle in which its request is presented. The bench drives requests on the falling edge and samples 2 ns after the next rising edge. It compares read data against its model of the line before applying that cycle's fill or eviction to the model, which matches the pre-update read rule. An adaptive instance and a fixed instance receive the same stimulus, and each is checked against its own capacity limits.

// File: rtl/ahw_pkg.sv
package ahw_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int CODE_W = 2;

  // wide: upper half is not a pure sign extension of the low half
  function automatic logic word_is_wide(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:HALF_W] != {HALF_W{w[HALF_W-1]}};
  endfunction

  // pool entry named by a nonzero code; block 0 grows up, block 1 grows down
  function automatic int slot_of_code(input logic [CODE_W-1:0] code, input logic blk,
                                      input int pool);
    return blk ? (pool - int'(code)) : (int'(code) - 1);
  endfunction

  // rebuild the 32-bit word from its stored pieces
  function automatic logic [WORD_W-1:0] rebuild(input logic [CODE_W-1:0] code,
                                                input logic [HALF_W-1:0] upper,
                                                input logic [HALF_W-1:0] lower);
    if (code == '0) return {{HALF_W{lower[HALF_W-1]}}, lower};
    return {upper, lower};
  endfunction
endpackage

// File: rtl/ahw_word_classify.sv
module ahw_word_classify
  import ahw_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int CW = $clog2(WORDS + 1)
) (
  input  logic [WORDS*WORD_W-1:0] data,
  output logic [WORDS-1:0]        wide_mask,
  output logic [WORDS*CODE_W-1:0] codes,
  output logic [CW-1:0]           wide_cnt
);
  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_cls
      assign wide_mask[g] = word_is_wide(data[g*WORD_W +: WORD_W]);
    end
  endgenerate

  // wide words take codes 1,2,3 in word order; beyond the cap the fill is refused
  always_comb begin
    int run;
    run = 0;
    codes = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (wide_mask[w]) begin
        run = run + 1;
        codes[w*CODE_W +: CODE_W] = (run > 3) ? 2'd3 : CODE_W'(run);
      end
    end
    wide_cnt = CW'(run);
  end
endmodule

// File: rtl/ahw_pool_ctrl.sv
module ahw_pool_ctrl #(
  parameter int WORDS = 4,
  parameter int POOL  = 4,
  parameter int CAP   = 3,
  localparam int CW = $clog2(WORDS + 1),
  localparam int UW = $clog2(POOL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_valid,
  input  logic          fill_blk,
  input  logic [CW-1:0] fill_wide_cnt,
  input  logic          evict_valid,
  input  logic          evict_blk,
  output logic          fill_ok,
  output logic [UW-1:0] used0,
  output logic [UW-1:0] used1,
  output logic          accept_q,
  output logic          reject_q
);
  logic [UW-1:0] used_q [2];
  logic          other_freed;
  int            other_used;
  int            free_slots;

  assign other_freed = evict_valid && (evict_blk != fill_blk);

  always_comb begin
    other_used = other_freed ? 0 : int'(used_q[~fill_blk]);
    free_slots = POOL - other_used;
    fill_ok    = (int'(fill_wide_cnt) <= CAP) && (int'(fill_wide_cnt) <= free_slots);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q[0] <= '0;
      used_q[1] <= '0;
      accept_q  <= 1'b0;
      reject_q  <= 1'b0;
    end else begin
      accept_q <= fill_valid && fill_ok;
      reject_q <= fill_valid && !fill_ok;
      for (int b = 0; b < 2; b++) begin
        if (fill_valid && fill_ok && (fill_blk == 1'(b)))
          used_q[b] <= UW'(fill_wide_cnt);
        else if (evict_valid && (evict_blk == 1'(b)))
          used_q[b] <= '0;
      end
    end
  end

  assign used0 = used_q[0];
  assign used1 = used_q[1];

  AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(used_q[0]) + int'(used_q[1])) <= POOL) else $error("pool overcommitted"); // R5
  AST_BLOCK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(used_q[0]) <= CAP) && (int'(used_q[1]) <= CAP)) else $error("cap exceeded"); // R4
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (accept_q ^ reject_q)) else $error("no single result"); // R10
  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |=> !(accept_q || reject_q)) else $error("stray result"); // R10
endmodule

// File: rtl/ahw_line_store.sv
module ahw_line_store
  import ahw_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int POOL  = 4,
  localparam int IW = $clog2(WORDS),
  localparam int PW = $clog2(POOL),
  localparam int UW = $clog2(POOL + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_blk,
  input  logic [WORDS*WORD_W-1:0] wr_data,
  input  logic [WORDS-1:0]        wr_wide,
  input  logic [WORDS*CODE_W-1:0] wr_codes,
  input  logic                    clr_en,
  input  logic                    clr_blk,
  input  logic                    rd_en,
  input  logic                    rd_blk,
  input  logic [IW-1:0]           rd_word,
  input  logic [UW-1:0]           used0,
  input  logic [UW-1:0]           used1,
  output logic                    rd_hit,
  output logic [WORD_W-1:0]       rd_data
);
  logic [HALF_W-1:0] low_q  [2][WORDS];
  logic [CODE_W-1:0] code_q [2][WORDS];
  logic [HALF_W-1:0] pool_q [POOL];
  logic [1:0]        valid_q;

  // read-side selection, named for the checks
  logic [CODE_W-1:0] rd_code;
  logic [HALF_W-1:0] rd_upper;
  logic [WORD_W-1:0] rd_word_val;

  always_comb begin
    rd_code     = code_q[rd_blk][rd_word];
    rd_upper    = '0;
    if (rd_code != '0)
      rd_upper = pool_q[PW'(slot_of_code(rd_code, rd_blk, POOL))];
    rd_word_val = rebuild(rd_code, rd_upper, low_q[rd_blk][rd_word]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rd_hit  <= 1'b0;
      rd_data <= '0;
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < WORDS; w++) begin
          low_q[b][w]  <= '0;
          code_q[b][w] <= '0;
        end
      for (int p = 0; p < POOL; p++) pool_q[p] <= '0;
    end else begin
      rd_hit  <= rd_en && valid_q[rd_blk];
      rd_data <= (rd_en && valid_q[rd_blk]) ? rd_word_val : '0;
      if (clr_en) begin
        valid_q[clr_blk] <= 1'b0;
        for (int w = 0; w < WORDS; w++) code_q[clr_blk][w] <= '0;
      end
      if (wr_en) begin
        valid_q[wr_blk] <= 1'b1;
        for (int w = 0; w < WORDS; w++) begin
          low_q[wr_blk][w]  <= wr_data[w*WORD_W +: HALF_W];
          code_q[wr_blk][w] <= wr_wide[w] ? wr_codes[w*CODE_W +: CODE_W] : '0;
          if (wr_wide[w])
            pool_q[PW'(slot_of_code(wr_codes[w*CODE_W +: CODE_W], wr_blk, POOL))]
              <= wr_data[w*WORD_W + HALF_W +: HALF_W];
        end
      end
    end
  end

  // entries referenced by stored codes, counted independently of the controller
  logic [UW-1:0] nz_cnt [2];
  always_comb begin
    for (int b = 0; b < 2; b++) begin
      nz_cnt[b] = '0;
      for (int w = 0; w < WORDS; w++)
        if (code_q[b][w] != '0) nz_cnt[b] = nz_cnt[b] + 1'b1;
    end
  end

  AST_CODES_MATCH_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (nz_cnt[0] == used0) && (nz_cnt[1] == used1)) else $error("code/usage mismatch"); // R9
  AST_EMPTY_HAS_NO_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q[0] |-> nz_cnt[0] == '0) and (!valid_q[1] |-> nz_cnt[1] == '0))
    else $error("evicted block keeps codes"); // R8
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_data == '0) else $error("data without hit"); // R1
endmodule

// File: rtl/ahw_line_alloc.sv
module ahw_line_alloc
  import ahw_pkg::*;
#(
  parameter int WORDS    = 4,
  parameter int ADAPTIVE = 1,
  localparam int POOL = (ADAPTIVE != 0) ? 4 : 2,
  localparam int CAP  = (ADAPTIVE != 0) ? 3 : 1,
  localparam int IW   = $clog2(WORDS),
  localparam int CW   = $clog2(WORDS + 1),
  localparam int UW   = $clog2(POOL + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_valid,
  input  logic                    fill_blk,
  input  logic [WORDS*WORD_W-1:0] fill_data,
  input  logic                    evict_valid,
  input  logic                    evict_blk,
  input  logic                    rd_valid,
  input  logic                    rd_blk,
  input  logic [IW-1:0]           rd_word,
  output logic                    fill_accept,
  output logic                    fill_reject,
  output logic                    rd_hit,
  output logic [WORD_W-1:0]       rd_data
);
  logic [WORDS-1:0]        wide_mask;
  logic [WORDS*CODE_W-1:0] codes;
  logic [CW-1:0]           wide_cnt;
  logic                    fill_ok;
  logic [UW-1:0]           used0, used1;
  logic                    do_write, do_clear;

  ahw_word_classify #(.WORDS(WORDS)) u_cls (
    .data(fill_data), .wide_mask(wide_mask), .codes(codes), .wide_cnt(wide_cnt)
  );

  ahw_pool_ctrl #(.WORDS(WORDS), .POOL(POOL), .CAP(CAP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_blk(fill_blk),
    .fill_wide_cnt(wide_cnt), .evict_valid(evict_valid), .evict_blk(evict_blk),
    .fill_ok(fill_ok), .used0(used0), .used1(used1),
    .accept_q(fill_accept), .reject_q(fill_reject)
  );

  assign do_write = fill_valid && fill_ok;
  assign do_clear = evict_valid && !(do_write && (fill_blk == evict_blk));

  ahw_line_store #(.WORDS(WORDS), .POOL(POOL)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(do_write), .wr_blk(fill_blk), .wr_data(fill_data),
    .wr_wide(wide_mask), .wr_codes(codes), .clr_en(do_clear), .clr_blk(evict_blk),
    .rd_en(rd_valid), .rd_blk(rd_blk), .rd_word(rd_word), .used0(used0), .used1(used1),
    .rd_hit(rd_hit), .rd_data(rd_data)
  );

  AST_ACCEPT_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (do_write && !(evict_valid && evict_blk != fill_blk) && rd_valid && rd_blk == fill_blk)
    ##1 (rd_valid && rd_blk == $past(fill_blk)) |=> rd_hit) else $error("accepted block missing"); // R11
  AST_EVICT_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    (do_clear && !(do_write && fill_blk == evict_blk)) ##1 (rd_valid && rd_blk == $past(evict_blk) && !(fill_valid && fill_blk == rd_blk))
    |=> !rd_hit) else $error("evicted block still hit"); // R8
endmodule

// File: tb/tb_ahw_line_alloc.sv
module tb_ahw_line_alloc;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fill_valid = 1'b0, fill_blk = 1'b0;
  logic [127:0] fill_data = '0;
  logic         evict_valid = 1'b0, evict_blk = 1'b0;
  logic         rd_valid = 1'b0, rd_blk = 1'b0;
  logic [1:0]   rd_word = '0;
  logic [1:0]   acc, rej, hit;
  logic [31:0]  rdat [2];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ahw_line_alloc #(.WORDS(4), .ADAPTIVE(1)) dut (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_data(fill_data),
    .evict_valid(evict_valid), .evict_blk(evict_blk), .rd_valid(rd_valid), .rd_blk(rd_blk),
    .rd_word(rd_word), .fill_accept(acc[0]), .fill_reject(rej[0]), .rd_hit(hit[0]), .rd_data(rdat[0])
  );

  ahw_line_alloc #(.WORDS(4), .ADAPTIVE(0)) dut_fx (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_data(fill_data),
    .evict_valid(evict_valid), .evict_blk(evict_blk), .rd_valid(rd_valid), .rd_blk(rd_blk),
    .rd_word(rd_word), .fill_accept(acc[1]), .fill_reject(rej[1]), .rd_hit(hit[1]), .rd_data(rdat[1])
  );

  // model: index 0 adaptive, index 1 fixed
  logic [31:0] mw [2][2][4];
  bit          mv [2][2];
  int          mu [2][2];
  int          capm  [2] = '{3, 1};
  int          poolm [2] = '{4, 2};

  function automatic bit b_narrow(input logic [31:0] w);
    int s;
    s = $signed(w);
    return (s >= -32768) && (s <= 32767);
  endfunction

  function automatic int b_wide_count(input logic [127:0] d);
    int n;
    n = 0;
    for (int i = 0; i < 4; i++) if (!b_narrow(d[i*32 +: 32])) n++;
    return n;
  endfunction

  function automatic logic [127:0] pk(input logic [31:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic check(input string req, input string what, input int m,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s mode%0d actual=%h expected=%h", req, what, m, act, exp);
    end
  endtask

  task automatic op(input string req, input bit fv, input bit fb, input logic [127:0] fd,
                    input bit ev, input bit eb, input bit rv, input bit rb, input int rw);
    fill_valid = fv; fill_blk = fb; fill_data = fd;
    evict_valid = ev; evict_blk = eb;
    rd_valid = rv; rd_blk = rb; rd_word = rw[1:0];
    @(posedge clk);
    #2;
    for (int m = 0; m < 2; m++) begin
      int nw, oth;
      bit ok;
      nw  = b_wide_count(fd);
      oth = (ev && eb != fb) ? 0 : mu[m][!fb];
      ok  = (nw <= capm[m]) && (nw <= poolm[m] - oth);
      check(req, "accept", m, {31'd0, acc[m]}, {31'd0, fv && ok});
      check(req, "reject", m, {31'd0, rej[m]}, {31'd0, fv && !ok});
      if (rv) begin
        check(req, "hit", m, {31'd0, hit[m]}, {31'd0, mv[m][rb]});
        check(req, "data", m, rdat[m], mv[m][rb] ? mw[m][rb][rw] : 32'd0);
      end else begin
        check(req, "idle hit", m, {31'd0, hit[m]}, 32'd0);
      end
      for (int b = 0; b < 2; b++) begin
        if (fv && ok && fb == b) begin
          mv[m][b] = 1'b1;
          mu[m][b] = nw;
          for (int i = 0; i < 4; i++) mw[m][b][i] = fd[i*32 +: 32];
        end else if (ev && eb == b) begin
          mv[m][b] = 1'b0;
          mu[m][b] = 0;
        end
      end
    end
    @(negedge clk);
    fill_valid = 1'b0; evict_valid = 1'b0; rd_valid = 1'b0;
  endtask

  task automatic rd(input string req, input bit b, input int w);
    op(req, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, b, w);
  endtask

  function automatic logic [31:0] rnd_word();
    if ($urandom % 4 == 0) return {16'h0100 | 16'($urandom), 16'($urandom)};
    if ($urandom % 2 == 0) return {16'h0000, 1'b0, 15'($urandom)};
    return {16'hffff, 1'b1, 15'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 2; b++) begin
        mv[m][b] = 1'b0; mu[m][b] = 0;
        for (int i = 0; i < 4; i++) mw[m][b][i] = '0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: empty line after reset
    for (int m = 0; m < 2; m++) begin
      check("R1", "reset accept", m, {31'd0, acc[m]}, 32'd0);
      check("R1", "reset hit", m, {31'd0, hit[m]}, 32'd0);
    end
    rd("R1", 1'b0, 0);
    rd("R1", 1'b1, 3);
    // R2: all narrow, including negative low halves
    op("R2", 1'b1, 1'b0, pk(32'h000003af, 32'h00000000, 32'hffff93af, 32'h00007401),
       1'b0, 1'b0, 1'b0, 1'b0, 0);
    for (int i = 0; i < 4; i++) rd("R2", 1'b0, i);
    // R3: one wide word in block 1
    op("R3", 1'b1, 1'b1, pk(32'h00003801, 32'hfffff8b2, 32'h01f09401, 32'h00000010),
       1'b0, 1'b0, 1'b0, 1'b0, 0);
    for (int i = 0; i < 4; i++) rd("R3", 1'b1, i);
    // R5/R6: three wide words in block 0 (adaptive fits 3+1, fixed over its cap of 1)
    op("R5", 1'b1, 1'b0, pk(32'h12345678, 32'h00000005, 32'h80000001, 32'h7fff0000),
       1'b0, 1'b0, 1'b1, 1'b0, 2);
    for (int i = 0; i < 4; i++) rd("R6", 1'b0, i);
    // R4: four wide words always refused; R7 line untouched
    op("R4", 1'b1, 1'b1, pk(32'h11110000, 32'h22220000, 32'h33330000, 32'h44440000),
       1'b0, 1'b0, 1'b0, 1'b0, 0);
    rd("R7", 1'b1, 2);
    rd("R7", 1'b0, 0);
    // R5: two wide words do not fit into the single free entry
    op("R5", 1'b1, 1'b1, pk(32'h55550000, 32'h00000001, 32'h66660001, 32'h00000002),
       1'b0, 1'b0, 1'b0, 1'b0, 0);
    rd("R7", 1'b1, 2);
    // R8: evict block 0, then the same fill fits
    op("R8", 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    rd("R8", 1'b0, 0);
    op("R8", 1'b1, 1'b1, pk(32'h55550000, 32'h00000001, 32'h66660001, 32'h00000002),
       1'b0, 1'b0, 1'b0, 1'b0, 0);
    rd("R8", 1'b1, 0);
    rd("R8", 1'b1, 2);
    // R9: block 0 takes two entries, then is overwritten with two new wide words
    op("R9", 1'b1, 1'b0, pk(32'h0abc0001, 32'h0def0002, 32'h00000003, 32'h00000004),
       1'b0, 1'b0, 1'b0, 1'b0, 0);
    op("R9", 1'b1, 1'b0, pk(32'h00000009, 32'hbeef1234, 32'hcafe5678, 32'hfffffff0),
       1'b0, 1'b0, 1'b1, 1'b0, 0);
    for (int i = 0; i < 4; i++) rd("R9", 1'b0, i);
    rd("R9", 1'b1, 0);
    // R11: fill of block 0 with 3 wide while block 1 is evicted in the same cycle
    op("R11", 1'b1, 1'b0, pk(32'h01010101, 32'h02020202, 32'h03030303, 32'h00000000),
       1'b1, 1'b1, 1'b1, 1'b1, 0);
    rd("R11", 1'b1, 0);
    rd("R11", 1'b0, 2);
    // R11: accepted fill and eviction on the same block, fill wins
    op("R11", 1'b1, 1'b1, pk(32'h00000001, 32'h00000002, 32'h00000003, 32'h00000004),
       1'b1, 1'b1, 1'b0, 1'b0, 0);
    rd("R11", 1'b1, 3);
    // R11: rejected fill with eviction on the same block, eviction applies
    op("R11", 1'b1, 1'b0, pk(32'h11110000, 32'h22220000, 32'h33330000, 32'h44440000),
       1'b1, 1'b0, 1'b0, 1'b0, 0);
    rd("R11", 1'b0, 0);
    // R10/R3: random mix of fills, evictions and reads
    for (int n = 0; n < 3000; n++) begin
      logic [127:0] d;
      d = pk(rnd_word(), rnd_word(), rnd_word(), rnd_word());
      op("R10", ($urandom % 3) == 0, 1'($urandom), d, ($urandom % 7) == 0, 1'($urandom),
         ($urandom % 4) != 0, 1'($urandom), int'($urandom % 4));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule